// File: doc/BRIEF.md
# Transmit Process Controller with Fill Threshold

This block sequences the transmit side of a network controller. Software raises a start command. The controller then asks for the next transmit descriptor and looks at its ownership flag. A descriptor that still belongs to the host puts the process to sleep and raises a sticky buffer-unavailable flag. A descriptor that belongs to the controller opens the FIFO write port, so frame bytes can be copied in from host memory.

A fill counter tracks the bytes held in the FIFO. Line transmission is launched with a one-cycle strobe once the count is strictly above a byte threshold. A 3-bit code picks that threshold from two families of levels. A frame whose last byte arrives before the threshold is crossed is launched at once. When the line side reports the frame done, the process fetches the next descriptor. If the start command has been withdrawn, it parks instead. A frame that is already in flight always completes first.

Top module: `tx_proc_ctrl`

## Requirements
- R1: After reset, `proc_state` is 0 (stopped), `fifo_level` is 0, and `desc_req`, `line_start`, `buf_unavail` and `fill_open` are all 0. State codes are: 0 stopped, 1 fetch, 2 suspended, 3 fill, 4 transmit.
- R2: With `cfg_start` high in the stopped state, the next cycle is fetch. `desc_req` stays high through every fetch cycle until `desc_ack`.
- R3: An acknowledged descriptor with `desc_host_owned`=1 moves the process to suspended and sets `buf_unavail`. From suspended, a `poll_demand` pulse returns it to fetch.
- R4: `buf_unavail` stays set until a cycle with `unavail_clr`=1 clears it. If a new set and a clear fall in the same cycle, the flag remains set.
- R5: An acknowledged descriptor with `desc_host_owned`=0 moves the process to fill. While `fill_open` is 1, each `wr_valid` beat adds `wr_bytes` to `fifo_level`, saturating at the counter maximum. Beats while `fill_open` is 0 leave `fifo_level` unchanged.
- R6: The threshold for `cfg_thr_code` = {bit2,bit1,bit0} is 128, 256, 512 or 1024 bytes for codes 0 to 3. It is 64, 128, 192 or 256 bytes for codes 4 to 7.
- R7: In fill, `line_start` pulses for exactly one cycle in the first cycle where `fifo_level` is greater than the threshold. It is not raised while the level equals the threshold. The next cycle is transmit.
- R8: A beat with `wr_last`=1 launches `line_start` in the following cycle even when the level is at or below the threshold. After that beat, `fill_open` is 0.
- R9: `line_done` in transmit, with `cfg_start` high, returns the process to fetch and clears `fifo_level` to 0.
- R10: With `cfg_start` low, fetch and suspended go to stopped in the next cycle. Fill and transmit keep running, and the process goes to stopped only on `line_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Transmit run command |
| cfg_thr_code | input | 3 | Threshold select code |
| poll_demand | input | 1 | Re-fetch request pulse while suspended |
| desc_req | output | 1 | Descriptor fetch request |
| desc_ack | input | 1 | Descriptor response valid |
| desc_host_owned | input | 1 | Descriptor ownership, 1 = host |
| wr_valid | input | 1 | Host data beat into FIFO |
| wr_bytes | input | 3 | Bytes in the beat |
| wr_last | input | 1 | Beat holds the last byte of the frame |
| fill_open | output | 1 | FIFO write port accepting beats |
| fifo_level | output | 12 | Bytes held for the current frame |
| line_start | output | 1 | Line transmission start strobe |
| line_done | input | 1 | Line side finished the frame |
| buf_unavail | output | 1 | Sticky buffer-unavailable flag |
| unavail_clr | input | 1 | Write-one-to-clear for the flag |
| proc_state | output | 3 | Process state code |

## Verification
Two functions of this block can land in the same cycle: a host-owned descriptor setting the unavailable flag, and software clearing that flag. The bench re-polls a host-owned descriptor while `unavail_clr` is held in the acknowledge cycle, and expects the flag to stay set. A second pairing is a withdrawn start command together with a frame still in flight. Here the bench expects transmit to hold until `line_done` and then land in stopped, not fetch.

// File: rtl/tx_proc_pkg.sv
package tx_proc_pkg;

  typedef enum logic [2:0] {
    ST_STOPPED = 3'd0,
    ST_FETCH   = 3'd1,
    ST_SUSP    = 3'd2,
    ST_FILL    = 3'd3,
    ST_XMIT    = 3'd4
  } tx_state_e;

  // start level in bytes for a threshold code
  function automatic logic [10:0] thr_bytes(input logic [2:0] code);
    logic [10:0] v;
    case (code)
      3'd0:    v = 11'd128;
      3'd1:    v = 11'd256;
      3'd2:    v = 11'd512;
      3'd3:    v = 11'd1024;
      3'd4:    v = 11'd64;
      3'd5:    v = 11'd128;
      3'd6:    v = 11'd192;
      default: v = 11'd256;
    endcase
    return v;
  endfunction

  // saturating byte accumulate
  function automatic logic [31:0] sat_add(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] maxv);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > {1'b0, maxv}) ? maxv : s[31:0];
  endfunction

endpackage

// File: rtl/tx_thr_sel.sv
module tx_thr_sel #(
  parameter int LVL_W   = 12,
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       code,
  output logic [LVL_W-1:0] thr
);
  import tx_proc_pkg::*;

  logic [LVL_W-1:0] thr_c;
  assign thr_c = LVL_W'(thr_bytes(code));

  generate
    if (REG_OUT) begin : g_reg
      logic [LVL_W-1:0] thr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_q <= LVL_W'(128);
        else        thr_q <= thr_c;
      end
      assign thr = thr_q;
    end else begin : g_comb
      assign thr = thr_c;
    end
  endgenerate

endmodule

// File: rtl/tx_fill_cnt.sv
module tx_fill_cnt #(
  parameter int LVL_W = 12,
  parameter int BW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [BW-1:0]    add_bytes,
  input  logic             last_in,
  output logic [LVL_W-1:0] level,
  output logic             last_seen
);
  import tx_proc_pkg::*;

  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic [LVL_W-1:0] level_nx;
  assign level_nx = LVL_W'(sat_add(32'(level), 32'(add_bytes), 32'(LVL_MAX)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level     <= '0;
      last_seen <= 1'b0;
    end else if (clr) begin
      level     <= '0;
      last_seen <= 1'b0;
    end else if (add_en) begin
      level <= level_nx;
      if (last_in) last_seen <= 1'b1;
    end
  end

  // R5: the count never wraps back down while not cleared
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> level >= $past(level));

endmodule

// File: rtl/tx_proc_fsm.sv
module tx_proc_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_start,
  input  logic       poll_demand,
  input  logic       desc_ack,
  input  logic       desc_host_owned,
  input  logic       go_line,
  input  logic       line_done,
  input  logic       unavail_clr,
  output tx_proc_pkg::tx_state_e state,
  output logic       desc_req,
  output logic       line_start,
  output logic       cnt_clr,
  output logic       buf_unavail
);
  import tx_proc_pkg::*;

  tx_state_e state_nx;
  logic      set_unavail;
  logic      frame_end;

  assign desc_req    = (state == ST_FETCH) && cfg_start;
  assign set_unavail = desc_req && desc_ack && desc_host_owned;
  assign line_start  = (state == ST_FILL) && go_line;
  assign frame_end   = (state == ST_XMIT) && line_done;
  assign cnt_clr     = frame_end || (state == ST_FETCH);

  always_comb begin
    state_nx = state;
    case (state)
      ST_STOPPED: if (cfg_start) state_nx = ST_FETCH;
      ST_FETCH: begin
        if (!cfg_start)           state_nx = ST_STOPPED;
        else if (desc_ack)        state_nx = desc_host_owned ? ST_SUSP : ST_FILL;
      end
      ST_SUSP: begin
        if (!cfg_start)           state_nx = ST_STOPPED;
        else if (poll_demand)     state_nx = ST_FETCH;
      end
      ST_FILL: if (go_line)       state_nx = ST_XMIT;
      ST_XMIT: if (line_done)     state_nx = cfg_start ? ST_FETCH : ST_STOPPED;
      default:                    state_nx = ST_STOPPED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_STOPPED;
      buf_unavail <= 1'b0;
    end else begin
      state <= state_nx;
      if (set_unavail)      buf_unavail <= 1'b1;
      else if (unavail_clr) buf_unavail <= 1'b0;
    end
  end

  // R2: a start from stopped raises the fetch request next cycle
  p_fetch_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOPPED && cfg_start) |=> desc_req);

  // R4: flag only drops on a clear
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_unavail && !unavail_clr) |=> buf_unavail);

  // R3: a host-owned answer always leaves the flag set
  p_susp_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_unavail |=> (buf_unavail && state == ST_SUSP));

  // R7: start strobe is a single cycle
  p_one_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

  // R10: transmit holds until the line reports done
  p_hold_xmit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XMIT && !line_done) |=> state == ST_XMIT);

endmodule

// File: rtl/tx_proc_ctrl.sv
module tx_proc_ctrl #(
  parameter int LVL_W   = 12,
  parameter int BW      = 3,
  parameter bit THR_REG = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_start,
  input  logic [2:0]       cfg_thr_code,
  input  logic             poll_demand,
  output logic             desc_req,
  input  logic             desc_ack,
  input  logic             desc_host_owned,
  input  logic             wr_valid,
  input  logic [BW-1:0]    wr_bytes,
  input  logic             wr_last,
  output logic             fill_open,
  output logic [LVL_W-1:0] fifo_level,
  output logic             line_start,
  input  logic             line_done,
  output logic             buf_unavail,
  input  logic             unavail_clr,
  output logic [2:0]       proc_state
);
  import tx_proc_pkg::*;

  tx_state_e        state;
  logic [LVL_W-1:0] thr;
  logic             last_seen;
  logic             cnt_clr;
  logic             wr_take;
  logic             above_thr;
  logic             go_line;

  assign fill_open  = (state == ST_FILL || state == ST_XMIT) && !last_seen;
  assign wr_take    = wr_valid && fill_open;
  assign above_thr  = fifo_level > thr;
  assign go_line    = above_thr || last_seen;
  assign proc_state = state;

  tx_thr_sel #(.LVL_W(LVL_W), .REG_OUT(THR_REG)) i_thr (
    .clk(clk), .rst_n(rst_n), .code(cfg_thr_code), .thr(thr)
  );

  tx_fill_cnt #(.LVL_W(LVL_W), .BW(BW)) i_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .add_en(wr_take),
    .add_bytes(wr_bytes), .last_in(wr_last), .level(fifo_level),
    .last_seen(last_seen)
  );

  tx_proc_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .poll_demand(poll_demand),
    .desc_ack(desc_ack), .desc_host_owned(desc_host_owned), .go_line(go_line),
    .line_done(line_done), .unavail_clr(unavail_clr), .state(state),
    .desc_req(desc_req), .line_start(line_start), .cnt_clr(cnt_clr),
    .buf_unavail(buf_unavail)
  );

  // R7/R8: launch only above the level or with the whole frame held
  p_launch_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (above_thr || last_seen));

  // R5: a closed write port leaves the count alone
  p_closed_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_open && !cnt_clr) |=> $stable(fifo_level));

  // R9: the level is empty after a frame completes
  p_clear_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 3'd4 && line_done) |=> fifo_level == '0);

endmodule

// File: tb/test_tx_proc_ctrl.sv
`timescale 1ns/1ps
module test_tx_proc_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_start = 0, poll_demand = 0, desc_ack = 0, desc_host_owned = 0;
  logic [2:0] cfg_thr_code = 0;
  logic wr_valid = 0, wr_last = 0, line_done = 0, unavail_clr = 0;
  logic [2:0] wr_bytes = 0;
  logic desc_req, fill_open, line_start, buf_unavail;
  logic [11:0] fifo_level;
  logic [2:0] proc_state;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  tx_proc_ctrl i_tx_proc_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_thr_code(cfg_thr_code),
    .poll_demand(poll_demand), .desc_req(desc_req), .desc_ack(desc_ack),
    .desc_host_owned(desc_host_owned), .wr_valid(wr_valid), .wr_bytes(wr_bytes),
    .wr_last(wr_last), .fill_open(fill_open), .fifo_level(fifo_level),
    .line_start(line_start), .line_done(line_done), .buf_unavail(buf_unavail),
    .unavail_clr(unavail_clr), .proc_state(proc_state)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int exp_thr(input int code);
    if (code >= 4) return 64 * ((code % 4) + 1);
    return 128 << code;
  endfunction

  task automatic to_fill();
    cfg_start = 1;
    while (proc_state != 3'd1) step();
    desc_ack = 1; desc_host_owned = 0;
    step();
    desc_ack = 0;
  endtask

  task automatic finish_frame(input int exp_state);
    line_done = 1;
    step();
    line_done = 0;
    chk("R9 state after done", proc_state, exp_state);
    chk("R9 level cleared", fifo_level, 0);
  endtask

  task automatic t_reset();
    chk("R1 state", proc_state, 0);
    chk("R1 level", fifo_level, 0);
    chk("R1 outs", {desc_req, line_start, buf_unavail, fill_open}, 0);
  endtask

  task automatic t_host_owned();
    cfg_start = 1;
    step();
    chk("R2 fetch", proc_state, 1);
    chk("R2 req", desc_req, 1);
    step();
    chk("R2 req held", desc_req, 1);
    desc_ack = 1; desc_host_owned = 1;
    step();
    desc_ack = 0;
    chk("R3 suspended", proc_state, 2);
    chk("R3 flag", buf_unavail, 1);
    wr_valid = 1; wr_bytes = 4;
    step();
    wr_valid = 0;
    chk("R5 ignored write", fifo_level, 0);
    chk("R4 sticky", buf_unavail, 1);
    poll_demand = 1;
    step();
    poll_demand = 0;
    chk("R3 poll refetch", proc_state, 1);
    desc_ack = 1; desc_host_owned = 1; unavail_clr = 1;
    step();
    desc_ack = 0; unavail_clr = 0;
    chk("R4 set wins over clear", buf_unavail, 1);
    unavail_clr = 1;
    step();
    unavail_clr = 0;
    chk("R4 w1c clear", buf_unavail, 0);
    cfg_start = 0;
    step();
    chk("R10 stop from suspended", proc_state, 0);
  endtask

  task automatic t_threshold(input int code);
    int th = exp_thr(code);
    int early = 0;
    cfg_thr_code = code[2:0];
    to_fill();
    chk("R5 fill state", proc_state, 3);
    chk("R5 port open", fill_open, 1);
    for (int b = 0; b < th / 4; b++) begin
      wr_valid = 1; wr_bytes = 4;
      step();
      if (line_start) early++;
    end
    wr_valid = 0;
    chk("R6 level at threshold", fifo_level, th);
    chk("R7 no start at equal", early, 0);
    wr_valid = 1; wr_bytes = 1;
    step();
    wr_valid = 0;
    chk("R7 start above", line_start, 1);
    chk("R7 still fill", proc_state, 3);
    step();
    chk("R7 pulse over", line_start, 0);
    chk("R7 transmit", proc_state, 4);
    finish_frame(1);
  endtask

  task automatic t_short_frame();
    cfg_thr_code = 3'd3;
    to_fill();
    wr_valid = 1; wr_bytes = 6;
    step();
    wr_bytes = 4; wr_last = 1;
    step();
    wr_valid = 0; wr_last = 0;
    chk("R8 start short", line_start, 1);
    chk("R8 port closed", fill_open, 0);
    step();
    chk("R8 transmit", proc_state, 4);
    wr_valid = 1; wr_bytes = 7;
    step();
    wr_valid = 0;
    chk("R8 late beat ignored", fifo_level, 10);
    finish_frame(1);
  endtask

  task automatic t_stop();
    cfg_thr_code = 3'd4;
    // stop while in fetch
    cfg_start = 0;
    step();
    chk("R10 stop from fetch", proc_state, 0);
    to_fill();
    cfg_start = 0;
    wr_valid = 1; wr_bytes = 5; wr_last = 1;
    step();
    wr_valid = 0; wr_last = 0;
    chk("R10 fill continues", proc_state, 3);
    step();
    chk("R10 transmit continues", proc_state, 4);
    step(); step();
    chk("R10 hold in transmit", proc_state, 4);
    finish_frame(0);
    chk("R10 no request", desc_req, 0);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_host_owned();
    for (int c = 0; c < 8; c++) t_threshold(c);
    t_short_frame();
    t_stop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule